// File: doc/BRIEF.md
# DMA Controller Clock-Stop and Register Guard

This block decides whether a DMA controller's clock runs, and it guards the controller's register bank. Software writes a stop flag in a dedicated register to ask for the controller's clock to be turned off. The block refuses that request while any channel still has its transfer enabled. It also refuses it while any channel has an interrupt flag raised with that interrupt enabled. When the request is accepted, a registered clock-enable output goes low. Writing the flag back to zero restores the clock.

While the clock is off, reads and writes to the channel registers do nothing. Two per-channel output enables, for the transfer-end strobe and for the request acknowledge, keep their last values and keep driving their pins. While a channel is running, its settings are locked. The one write allowed is one that only drops its transfer enable. Any write that is turned away raises a one-cycle error on the bus response.

Top module: `dma_clkstop_ctrl`

## Requirements
- R1: After a synchronous reset, clk_en is 1, bus_err is 0, and every channel field, ch_enable, tend_oe and ack_oe are 0.
- R2: Address 0 holds the stop flag in bit 0. A write there that is not refused sets the flag to wdata bit 0, and clk_en becomes its inverse one cycle after the write. A read of address 0 returns the flag in bit 0 and zero in all other bits, whether the clock is running or stopped.
- R3: A write of 1 to the stop flag while any ch_enable bit is 1 is refused. clk_en stays unchanged and bus_err pulses for one cycle.
- R4: A write of 1 to the stop flag is also refused while, for some channel, ch_irq_flag and that channel's interrupt-enable bit are both 1. A raised flag whose enable is 0 does not block the stop.
- R5: While clk_en is 0, a write to a channel register changes nothing and pulses bus_err, and a read of a channel register returns 0.
- R6: While clk_en is 0, tend_oe, ack_oe and ch_enable hold their values.
- R7: A write to a channel whose transfer enable is 1 is refused if wdata bit 0 is 1; the channel keeps its value and bus_err pulses. If wdata bit 0 is 0, only the transfer enable is cleared, and no error is raised.
- R8: Channel c sits at address c+1. Its fields are: bit 0 transfer enable, bit 1 interrupt enable, bit 2 transfer-end output enable, bit 3 acknowledge output enable, and bits 15:8 an 8-bit setting. Bits 7:4 read as 0. A write to an idle channel while running stores all fields, and a read returns them one cycle later.
- R9: A write to an address above NUM_CH changes nothing and pulses bus_err. A read there returns 0.
- R10: clk_en changes only in the cycle after an accepted stop-flag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse for a refused write |
| ch_irq_flag | input | NUM_CH | Per-channel interrupt flag from the transfer engine |
| clk_en | output | 1 | Registered clock enable for the controller |
| ch_enable | output | NUM_CH | Per-channel transfer enable |
| tend_oe | output | NUM_CH | Per-channel transfer-end output enable |
| ack_oe | output | NUM_CH | Per-channel acknowledge output enable |

## Verification
The stop request is tried four ways: with all channels idle, with a flag raised but its enable cleared, with a flag raised and its enable set, and with a channel running. Together these separate the refusal caused by a running transfer from the refusal caused by an interrupt, and show that an unmasked-off flag alone does not block. Channel writes are sent while running and while stopped, to both idle and busy channels, with and without bit 0 set. This separates the lock that the stop state applies from the per-channel lock and from the clear-only path. Writes and reads to an unmapped address show that the decode rejects them.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int SET_W = 8;

  typedef struct packed {
    logic [SET_W-1:0] set;
    logic [3:0]       rsv;
    logic             akoe;
    logic             teoe;
    logic             ien;
    logic             xen;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/dcs_stop_reg.sv
module dcs_stop_reg #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stop,
  input  logic              wbit,
  input  logic [NUM_CH-1:0] xen,
  input  logic [NUM_CH-1:0] ien,
  input  logic [NUM_CH-1:0] irq_flag,
  output logic              run_q,
  output logic              refuse
);
  logic busy;

  assign busy   = (|xen) | (|(ien & irq_flag));
  assign refuse = wr_stop & wbit & busy;

  always_ff @(posedge clk) begin
    if (rst)
      run_q <= 1'b1;
    else if (wr_stop && !refuse)
      run_q <= ~wbit;
  end
endmodule

// File: rtl/dcs_chan_reg.sv
module dcs_chan_reg
  import dcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_en,
  input  ch_cfg_t wcfg,
  output ch_cfg_t cfg,
  output logic    reject
);
  logic unused_rsv;
  assign unused_rsv = ^wcfg.rsv;

  assign reject = wr_en & cfg.xen & wcfg.xen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      if (cfg.xen) begin
        if (!wcfg.xen) cfg.xen <= 1'b0;
      end else begin
        cfg      <= wcfg;
        cfg.rsv  <= '0;
      end
    end
  end
endmodule

// File: rtl/dma_clkstop_ctrl.sv
module dma_clkstop_ctrl
  import dcs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [NUM_CH-1:0] ch_irq_flag,
  output logic              clk_en,
  output logic [NUM_CH-1:0] ch_enable,
  output logic [NUM_CH-1:0] tend_oe,
  output logic [NUM_CH-1:0] ack_oe
);
  ch_cfg_t             cfg [NUM_CH];
  ch_cfg_t             wcfg;
  logic [NUM_CH-1:0]   hit, rej, ien_v;
  logic                wr_stop, refuse, bad_wr, run;
  logic [DATA_W-1:0]   rd_d;

  assign wcfg    = ch_cfg_t'(bus_wdata[CFG_W-1:0]);
  assign wr_stop = bus_sel & bus_wr & (bus_addr == '0);
  assign bad_wr  = bus_sel & bus_wr & (bus_addr > ADDR_W'(NUM_CH));

  generate
    if (DATA_W > CFG_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:CFG_W];
    end
  endgenerate

  dcs_stop_reg #(.NUM_CH(NUM_CH)) u_stop (
    .clk(clk), .rst(rst), .wr_stop(wr_stop), .wbit(bus_wdata[0]),
    .xen(ch_enable), .ien(ien_v), .irq_flag(ch_irq_flag),
    .run_q(run), .refuse(refuse)
  );

  assign clk_en = run;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign hit[c] = bus_sel & bus_wr & (bus_addr == ADDR_W'(c + 1));
    dcs_chan_reg u_ch (
      .clk(clk), .rst(rst), .wr_en(hit[c] & run), .wcfg(wcfg),
      .cfg(cfg[c]), .reject(rej[c])
    );
    assign ch_enable[c] = cfg[c].xen;
    assign ien_v[c]     = cfg[c].ien;
    assign tend_oe[c]   = cfg[c].teoe;
    assign ack_oe[c]    = cfg[c].akoe;
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == '0) begin
      rd_d[0] = ~run;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (bus_addr == ADDR_W'(c + 1) && run)
          rd_d[CFG_W-1:0] = cfg[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_err   <= refuse | bad_wr | (|rej) | ((|hit) & ~run);
      bus_rdata <= (bus_sel && !bus_wr) ? rd_d : '0;
    end
  end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_err,
  input logic [NUM_CH-1:0] ch_irq_flag,
  input logic [NUM_CH-1:0] ien_v,
  input logic              clk_en,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [NUM_CH-1:0] tend_oe,
  input logic [NUM_CH-1:0] ack_oe
);
  logic stop_wr, busy;
  assign stop_wr = bus_sel && bus_wr && (bus_addr == '0);
  assign busy    = (|ch_enable) || (|(ch_irq_flag & ien_v));

  a_r1_reset: assert property (@(posedge clk) rst |=> (clk_en && !bus_err && ch_enable == '0));

  a_r2_stop_accept: assert property (@(posedge clk) disable iff (rst)
    (stop_wr && !(bus_wdata[0] && busy)) |=> (clk_en == !$past(bus_wdata[0])));

  a_r3_refuse_busy: assert property (@(posedge clk) disable iff (rst)
    (stop_wr && bus_wdata[0] && (|ch_enable)) |=> (bus_err && clk_en == $past(clk_en)));

  a_r4_refuse_irq: assert property (@(posedge clk) disable iff (rst)
    (stop_wr && bus_wdata[0] && (|(ch_irq_flag & ien_v))) |=> (bus_err && clk_en == $past(clk_en)));

  a_r5_stopped_err: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && bus_sel && bus_wr && bus_addr != '0) |=> bus_err);

  a_r6_oe_hold: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(tend_oe) && $stable(ack_oe) && $stable(ch_enable)));

  a_r10_clk_en_edge: assert property (@(posedge clk) disable iff (rst)
    !stop_wr |=> $stable(clk_en));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_r7
    a_r7_busy_reject: assert property (@(posedge clk) disable iff (rst)
      (clk_en && bus_sel && bus_wr && bus_addr == ADDR_W'(c + 1) && ch_enable[c] && bus_wdata[0])
      |=> (bus_err && ch_enable[c] && $stable(tend_oe)));
  end
endmodule

bind dma_clkstop_ctrl dcs_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_err(bus_err), .ch_irq_flag(ch_irq_flag), .ien_v(ien_v),
  .clk_en(clk_en), .ch_enable(ch_enable), .tend_oe(tend_oe), .ack_oe(ack_oe)
);

// File: tb/sim_dma_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_dma_clkstop_ctrl;
  localparam int N = 4;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 0, rst = 1;
  logic sel = 0, wr_i = 0;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] rdata;
  logic err, clk_en;
  logic [N-1:0] flag = 0, ch_enable, tend_oe, ack_oe;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_run, m_err, m_rd;
  int m_xen[N], m_ien[N], m_te[N], m_ak[N], m_set[N];

  always #2.5 clk = ~clk;

  dma_clkstop_ctrl #(.NUM_CH(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr_i), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err), .ch_irq_flag(flag),
    .clk_en(clk_en), .ch_enable(ch_enable), .tend_oe(tend_oe), .ack_oe(ack_oe)
  );

  function automatic int pack(int c);
    return (m_set[c] << 8) | (m_ak[c] << 3) | (m_te[c] << 2) | (m_ien[c] << 1) | m_xen[c];
  endfunction

  always @(posedge clk) begin
    int a, d, busy;
    a = int'(addr); d = int'(wdata);
    if (rst) begin
      m_run = 1; m_err = 0; m_rd = 0;
      for (int c = 0; c < N; c++) begin
        m_xen[c] = 0; m_ien[c] = 0; m_te[c] = 0; m_ak[c] = 0; m_set[c] = 0;
      end
    end else begin
      busy = 0;
      for (int c = 0; c < N; c++)
        if (m_xen[c] == 1 || (m_ien[c] == 1 && flag[c])) busy = 1;
      m_err = 0;
      m_rd = 0;
      if (sel && !wr_i) begin
        if (a == 0) m_rd = (m_run == 1) ? 0 : 1;
        else if (a <= N && m_run == 1) m_rd = pack(a - 1);
      end
      if (sel && wr_i) begin
        if (a == 0) begin
          if ((d & 1) && busy) m_err = 1;
          else m_run = (d & 1) ? 0 : 1;
        end else if (a <= N) begin
          if (m_run == 0) m_err = 1;
          else if (m_xen[a-1] == 1) begin
            if ((d & 1) == 0) m_xen[a-1] = 0;
            else m_err = 1;
          end else begin
            m_xen[a-1] = d & 1; m_ien[a-1] = (d >> 1) & 1;
            m_te[a-1] = (d >> 2) & 1; m_ak[a-1] = (d >> 3) & 1;
            m_set[a-1] = (d >> 8) & 255;
          end
        end else m_err = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int bad;
      bad = 0;
      if (int'(clk_en) != m_run || int'(err) != m_err || int'(rdata) != m_rd) bad = 1;
      for (int c = 0; c < N; c++)
        if (int'(ch_enable[c]) != m_xen[c] || int'(tend_oe[c]) != m_te[c] || int'(ack_oe[c]) != m_ak[c]) bad = 1;
      checks++;
      if (bad) begin
        failures++;
        $display("FAIL %s model: clk_en=%0d err=%0d rdata=%h en=%b te=%b ak=%b exp clk_en=%0d err=%0d rdata=%h",
                 cur_req, clk_en, err, rdata, ch_enable, tend_oe, ack_oe, m_run, m_err, m_rd);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit w, input int a, input int d);
    @(negedge clk); #1;
    sel = 1; wr_i = w; addr = AW'(a); wdata = DW'(d);
    @(negedge clk); #1;
    sel = 0; wr_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    cur_req = "R1";
    chk("R1 clk_en", int'(clk_en), 1);
    chk("R1 outputs", int'({ch_enable, tend_oe, ack_oe, err}), 0);

    cur_req = "R8";
    op(1, 1, 16'h5A0C);
    op(0, 1, 0);
    chk("R8 ch0 readback", int'(rdata), 16'h5A0C);
    chk("R8 ch0 oe", int'({tend_oe[0], ack_oe[0]}), 3);
    op(1, 2, 16'h01F2);
    op(0, 2, 0);
    chk("R8 ch1 rsv dropped", int'(rdata), 16'h0102);

    cur_req = "R4";
    flag = 4'b0001;
    cur_req = "R2";
    op(1, 0, 1);
    chk("R2 stop accepted, flag without enable", int'(clk_en), 0);
    op(0, 0, 0);
    chk("R2 stop readback", int'(rdata), 1);

    cur_req = "R6";
    chk("R6 oe held", int'({tend_oe[0], ack_oe[0]}), 3);
    cur_req = "R5";
    op(1, 1, 0);
    chk("R5 stopped write err", int'(err), 1);
    op(0, 1, 0);
    chk("R5 stopped read zero", int'(rdata), 0);
    chk("R6 oe held after write", int'(tend_oe[0]), 1);

    cur_req = "R2";
    op(1, 0, 0);
    chk("R2 clock restored", int'(clk_en), 1);
    op(0, 1, 0);
    chk("R5 write while stopped had no effect", int'(rdata), 16'h5A0C);

    cur_req = "R4";
    flag = 4'b0010;
    op(1, 0, 1);
    chk("R4 refused err", int'(err), 1);
    chk("R4 clk_en kept", int'(clk_en), 1);
    flag = 0;

    cur_req = "R3";
    op(1, 3, 16'h3305);
    op(1, 0, 1);
    chk("R3 refused err", int'(err), 1);
    chk("R3 clk_en kept", int'(clk_en), 1);

    cur_req = "R7";
    op(1, 3, 16'h4401);
    chk("R7 busy write err", int'(err), 1);
    op(0, 3, 0);
    chk("R7 busy write no change", int'(rdata), 16'h3305);
    op(1, 3, 16'h7700);
    chk("R7 clear no err", int'(err), 0);
    op(0, 3, 0);
    chk("R7 clear only enable", int'(rdata), 16'h3304);

    cur_req = "R9";
    op(1, 7, 16'hFFFF);
    chk("R9 bad addr err", int'(err), 1);
    op(0, 7, 0);
    chk("R9 bad addr read", int'(rdata), 0);

    cur_req = "R10";
    op(1, 0, 1);
    chk("R10 stop after idle", int'(clk_en), 0);
    repeat (3) @(negedge clk);
    chk("R10 clk_en steady", int'(clk_en), 0);
    op(1, 0, 0);
    chk("R10 restored", int'(clk_en), 1);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule